// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a parallel RGB display running on a single pixel clock. A small register port programs four horizontal lengths and four vertical lengths (sync pulse, back porch, visible area, front porch), each written as its count minus one. A per-signal polarity register decides whether horizontal sync, vertical sync, data-enable and pixel data are driven active-high or active-low.

A run bit starts and stops the raster. When stopped, every timing output sits at its inactive level and the coordinate outputs read zero. Each time a frame begins while running, a sticky status bit is set. Software clears it by writing 1, and it reaches the interrupt pin only when the matching mask bit is set. Pixel data enters from an external fetch stage, is inverted or passed as the polarity asks, and is forced to a blank level outside the visible area.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset all registers are zero: the run bit is clear, every polarity bit is 0 (active-low), so hsync_o, vsync_o and de_o are 1, pix_o is all ones, x_o and y_o are 0 and irq_o is 0.
- R2: While running, each line is the horizontal sync pulse, then back porch, then visible area, then front porch, each lasting the programmed field value plus one pixel clocks.
- R3: The vertical position advances once per completed line, through vertical sync, back porch, visible lines and front porch, each lasting its field value plus one lines. Vertical sync starts together with a horizontal sync pulse.
- R4: Data-enable is active only when both directions are in their visible area. x_o counts 0 upward through the horizontal visible area and is 0 elsewhere. y_o counts 0 upward through the vertical visible lines and is 0 elsewhere.
- R5: Polarity register bit 0 controls hsync_o, bit 1 controls vsync_o and bit 2 controls de_o. A set bit makes that output active-high. A clear bit makes it active-low.
- R6: Polarity bit 3 controls pixel data. When set, pix_o equals pix_i during data-enable and is all zeros otherwise. When clear, pix_o is the bitwise inverse of pix_i during data-enable and is all ones otherwise.
- R7: Writing 1 to control bit 0 starts the raster at the first clock of horizontal and vertical sync in the cycle after the write. Writing 0 stops it, which returns every timing output to its inactive level and x_o and y_o to 0.
- R8: The status bit is set in the cycle after each frame's first clock while running. It is cleared only by writing 1 to status bit 0, and it is never set while stopped.
- R9: irq_o is the status bit ANDed with mask bit 0. The mask does not change the status bit.
- R10: The word addresses are 0 control, 1 interrupt mask, 2 status, 3 polarity, and 4 to 11 for the horizontal sync, back, visible and front lengths followed by the vertical ones in the same order. rdata_o returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| pix_i | input | PIX_W | Pixel from the fetch stage |
| pix_o | output | PIX_W | Pixel after polarity and blanking |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| x_o | output | LEN_W | Column inside the visible area |
| y_o | output | LEN_W | Line inside the visible area |
| irq_o | output | 1 | Masked frame interrupt |

## Verification
A wrong phase or a wrong count in the horizontal counter shows within one line as a sync pulse or a visible run of the wrong width, or as an x_o value out of sequence. A wrong vertical state needs at most one frame to surface, either through vsync_o and y_o or through the status bit being set at the wrong time. The bench compares every output cycle by cycle against a frame model across whole frames. This includes the first cycle after start, so a counter that restarts in the wrong phase is caught at once.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;

  localparam int ADR_CTRL = 0;
  localparam int ADR_MASK = 1;
  localparam int ADR_STAT = 2;
  localparam int ADR_POL  = 3;
  localparam int ADR_LEN0 = 4;
  localparam int NUM_LEN  = 8;

  localparam int POL_HS   = 0;
  localparam int POL_VS   = 1;
  localparam int POL_DE   = 2;
  localparam int POL_DATA = 3;

  // length slots inside the length array
  localparam int L_HS = 0;
  localparam int L_HB = 1;
  localparam int L_HA = 2;
  localparam int L_HF = 3;
  localparam int L_VS = 4;
  localparam int L_VB = 5;
  localparam int L_VA = 6;
  localparam int L_VF = 7;
endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             step_i,
  input  logic [LEN_W-1:0] sync_len_i,
  input  logic [LEN_W-1:0] back_len_i,
  input  logic [LEN_W-1:0] act_len_i,
  input  logic [LEN_W-1:0] front_len_i,
  output logic             in_sync_o,
  output logic             in_act_o,
  output logic             origin_o,
  output logic             last_o,
  output logic [LEN_W-1:0] coord_o
);
  phase_e           phase_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cur_len;
  logic             at_end;

  always_comb begin
    unique case (phase_q)
      PH_SYNC:  cur_len = sync_len_i;
      PH_BACK:  cur_len = back_len_i;
      PH_ACT:   cur_len = act_len_i;
      default:  cur_len = front_len_i;
    endcase
  end

  // >= keeps the counter bounded if a length shrinks mid-phase
  assign at_end = (cnt_q >= cur_len);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (!run_i) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (step_i) begin
      if (at_end) begin
        phase_q <= phase_e'(2'(phase_q + 2'd1));
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign in_sync_o = (phase_q == PH_SYNC);
  assign in_act_o  = (phase_q == PH_ACT);
  assign origin_o  = (phase_q == PH_SYNC) && (cnt_q == '0);
  assign last_o    = (phase_q == PH_FRONT) && at_end;
  assign coord_o   = in_act_o ? cnt_q : '0;
endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_start_i,
  output logic              run_o,
  output logic              mask_o,
  output logic              stat_o,
  output logic [3:0]        pol_o,
  output logic [LEN_W-1:0]  len_o [NUM_LEN]
);
  logic             run_q, mask_q, stat_q;
  logic [3:0]       pol_q;
  logic [LEN_W-1:0] len_q [NUM_LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mask_q <= 1'b0;
      pol_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_W'(ADR_CTRL)) run_q  <= wdata_i[0];
      if (addr_i == ADDR_W'(ADR_MASK)) mask_q <= wdata_i[0];
      if (addr_i == ADDR_W'(ADR_POL))  pol_q  <= wdata_i[3:0];
    end
  end

  for (genvar i = 0; i < NUM_LEN; i++) begin : g_len
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) len_q[i] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(ADR_LEN0 + i))
        len_q[i] <= wdata_i[LEN_W-1:0];
    end
    assign len_o[i] = len_q[i];
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else if (frame_start_i) stat_q <= 1'b1;
    else if (wr_en_i && addr_i == ADDR_W'(ADR_STAT) && wdata_i[0]) stat_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(ADR_CTRL): rdata_o[0]   = run_q;
      ADDR_W'(ADR_MASK): rdata_o[0]   = mask_q;
      ADDR_W'(ADR_STAT): rdata_o[0]   = stat_q;
      ADDR_W'(ADR_POL):  rdata_o[3:0] = pol_q;
      default: begin
        for (int i = 0; i < NUM_LEN; i++)
          if (addr_i == ADDR_W'(ADR_LEN0 + i)) rdata_o[LEN_W-1:0] = len_q[i];
      end
    endcase
  end

  assign run_o  = run_q;
  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign pol_o  = pol_q;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int PIX_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [PIX_W-1:0]  pix_i,
  output logic [PIX_W-1:0]  pix_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [LEN_W-1:0]  x_o,
  output logic [LEN_W-1:0]  y_o,
  output logic              irq_o
);
  logic             run_q, mask_q, stat_q;
  logic [3:0]       pol_q;
  logic [LEN_W-1:0] len_q [NUM_LEN];
  logic             frame_start;

  logic h_sync, h_act, h_origin, h_last;
  logic v_sync, v_act, v_origin, v_last;
  logic [LEN_W-1:0] h_coord, v_coord;
  logic hs_act, vs_act, de_act;

  dtg_regs #(.LEN_W(LEN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .frame_start_i(frame_start),
    .run_o(run_q), .mask_o(mask_q), .stat_o(stat_q), .pol_o(pol_q),
    .len_o(len_q)
  );

  dtg_axis #(.LEN_W(LEN_W)) u_h (
    .clk_i, .rst_ni, .run_i(run_q), .step_i(1'b1),
    .sync_len_i(len_q[L_HS]), .back_len_i(len_q[L_HB]),
    .act_len_i(len_q[L_HA]), .front_len_i(len_q[L_HF]),
    .in_sync_o(h_sync), .in_act_o(h_act), .origin_o(h_origin),
    .last_o(h_last), .coord_o(h_coord)
  );

  dtg_axis #(.LEN_W(LEN_W)) u_v (
    .clk_i, .rst_ni, .run_i(run_q), .step_i(h_last),
    .sync_len_i(len_q[L_VS]), .back_len_i(len_q[L_VB]),
    .act_len_i(len_q[L_VA]), .front_len_i(len_q[L_VF]),
    .in_sync_o(v_sync), .in_act_o(v_act), .origin_o(v_origin),
    .last_o(v_last), .coord_o(v_coord)
  );

  assign frame_start = run_q & h_origin & v_origin;

  assign hs_act = run_q & h_sync;
  assign vs_act = run_q & v_sync;
  assign de_act = run_q & h_act & v_act;

  assign hsync_o = pol_q[POL_HS] ? hs_act : ~hs_act;
  assign vsync_o = pol_q[POL_VS] ? vs_act : ~vs_act;
  assign de_o    = pol_q[POL_DE] ? de_act : ~de_act;

  always_comb begin
    if (de_act) pix_o = pol_q[POL_DATA] ? pix_i : ~pix_i;
    else        pix_o = pol_q[POL_DATA] ? '0 : '1;
  end

  assign x_o   = run_q ? h_coord : '0;
  assign y_o   = run_q ? v_coord : '0;
  assign irq_o = stat_q & mask_q;
endmodule

// File: rtl/dtg_sva.sv
module dtg_sva #(
  parameter int LEN_W  = 12,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              run_q,
  input logic              mask_q,
  input logic              stat_q,
  input logic              hs_act,
  input logic              vs_act,
  input logic              de_act,
  input logic              irq_o,
  input logic [LEN_W-1:0]  x_o,
  input logic [LEN_W-1:0]  y_o,
  input logic [LEN_W-1:0]  ha_len
);
  logic stat_clr;
  assign stat_clr = wr_en_i && (addr_i == ADDR_W'(2)) && wdata_i[0];

  AST_STOP_COORD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (x_o == '0) && (y_o == '0)); // R7
  AST_DE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_act |-> run_q); // R4
  AST_X_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_o <= ha_len); // R4
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mask_q && stat_q); // R9
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q && !stat_clr |=> stat_q); // R8
  AST_STAT_QUIET_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q && !run_q |=> !stat_q); // R8
  AST_VSYNC_ON_HSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vs_act) |-> hs_act); // R3
endmodule

bind disp_timing_gen dtg_sva #(.LEN_W(LEN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .run_q(run_q), .mask_q(mask_q), .stat_q(stat_q),
  .hs_act(hs_act), .vs_act(vs_act), .de_act(de_act), .irq_o(irq_o),
  .x_o(x_o), .y_o(y_o), .ha_len(len_q[2])
);

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;
  localparam int LEN_W = 12, DATA_W = 16, ADDR_W = 4, PIX_W = 24;
  // test raster: H 2/3/4/2 = 11 clocks, V 1/1/3/2 = 7 lines
  localparam int HS = 2, HB = 3, HA = 4, HF = 2, HT = HS + HB + HA + HF;
  localparam int VS = 1, VB = 1, VA = 3, VF = 2, VT = VS + VB + VA + VF;
  localparam logic [PIX_W-1:0] PIX = 24'h5A3C11;

  typedef struct packed {
    logic hs, vs, de;
    logic [LEN_W-1:0] x, y;
    logic [PIX_W-1:0] pix;
  } exp_t;

  logic clk = 0, rst_ni = 0;
  logic wr_en_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0, rdata_o;
  logic [PIX_W-1:0] pix_i = PIX, pix_o;
  logic hsync_o, vsync_o, de_o, irq_o;
  logic [LEN_W-1:0] x_o, y_o;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];
  logic [3:0] cur_pol;

  always #5 clk = ~clk;

  disp_timing_gen #(.LEN_W(LEN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PIX_W(PIX_W)) dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .pix_i, .pix_o, .hsync_o, .vsync_o, .de_o, .x_o, .y_o, .irq_o);

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    wr_en_i = 1; addr_i = ADDR_W'(a); wdata_i = DATA_W'(d);
    @(posedge clk); #1;
    wr_en_i = 0;
  endtask

  task automatic reg_rd(input int a, output int d);
    @(negedge clk);
    addr_i = ADDR_W'(a); #1;
    d = int'(rdata_o);
  endtask

  // model of cycle t after start, from the requirements
  function automatic exp_t model(input int t, input logic [3:0] pol);
    exp_t e;
    int px, ln;
    logic hsa, vsa, hact, vact;
    px = t % HT; ln = (t / HT) % VT;
    hsa = px < HS; vsa = ln < VS;
    hact = (px >= HS + HB) && (px < HS + HB + HA);
    vact = (ln >= VS + VB) && (ln < VS + VB + VA);
    e.hs = pol[0] ? hsa : ~hsa;
    e.vs = pol[1] ? vsa : ~vsa;
    e.de = pol[2] ? (hact & vact) : ~(hact & vact);
    e.x = hact ? LEN_W'(px - HS - HB) : '0;
    e.y = vact ? LEN_W'(ln - VS - VB) : '0;
    if (hact & vact) e.pix = pol[3] ? PIX : ~PIX;
    else e.pix = pol[3] ? '0 : '1;
    return e;
  endfunction

  // driver: starts the raster and queues expected frames
  task automatic run_frames(input int cycles, input logic [3:0] pol);
    cur_pol = pol;
    reg_wr(0, 1); // R7 start
    for (int t = 0; t < cycles; t++) q.push_back(model(t, pol));
    wait (q.size() == 0);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check("R2/R5 hsync", hsync_o, e.hs);
        check("R3/R5 vsync", vsync_o, e.vs);
        check("R4/R5 de", de_o, e.de);
        check("R4 x", x_o, e.x);
        check("R4 y", y_o, e.y);
        check("R6 pix", pix_o, e.pix);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hsync", hsync_o, 1); check("R1 vsync", vsync_o, 1);
    check("R1 de", de_o, 1); check("R1 pix", pix_o, {PIX_W{1'b1}});
    check("R1 x", x_o, 0); check("R1 y", y_o, 0); check("R1 irq", irq_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    reg_rd(0, d); check("R1 ctrl", d, 0);

    reg_wr(4, HS - 1); reg_wr(5, HB - 1); reg_wr(6, HA - 1); reg_wr(7, HF - 1);
    reg_wr(8, VS - 1); reg_wr(9, VB - 1); reg_wr(10, VA - 1); reg_wr(11, VF - 1);
    reg_wr(3, 4'b0111); reg_wr(1, 1);
    reg_rd(6, d); check("R10 hact len", d, HA - 1);
    reg_rd(11, d); check("R10 vfront len", d, VF - 1);
    reg_rd(3, d); check("R10 pol", d, 4'b0111);

    run_frames(2 * VT * HT, 4'b0111); // R2 R3 R4 R5 R6

    // R8 status set at frame start, R9 irq with mask
    reg_rd(2, d); check("R8 stat set", d, 1);
    check("R9 irq masked-in", irq_o, 1);
    reg_wr(2, 1);
    reg_rd(2, d); check("R8 w1c", d, 0);
    check("R9 irq after clear", irq_o, 0);
    reg_wr(1, 0);
    repeat (VT * HT + 5) @(negedge clk);
    reg_rd(2, d); check("R9 stat set unmasked", d, 1);
    check("R9 irq masked-out", irq_o, 0);
    reg_wr(2, 0);
    reg_rd(2, d); check("R8 write 0 no clear", d, 1);

    // R7 stop
    reg_wr(0, 0);
    repeat (3) @(negedge clk);
    check("R7 hsync idle", hsync_o, 0); check("R7 vsync idle", vsync_o, 0);
    check("R7 de idle", de_o, 0); check("R7 pix idle", pix_o, {PIX_W{1'b1}});
    check("R7 x", x_o, 0); check("R7 y", y_o, 0);
    reg_wr(2, 1);
    repeat (2 * VT * HT) @(negedge clk);
    reg_rd(2, d); check("R8 quiet when stopped", d, 0);

    // restart with opposite polarities
    reg_wr(3, 4'b1000);
    @(negedge clk);
    check("R5 hsync idle low-active", hsync_o, 1);
    check("R6 pix idle high-active", pix_o, 0);
    run_frames(VT * HT + 3, 4'b1000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule